// File: doc/BRIEF.md
# DRAM Clock-Enable Power State Tracker

This block sits beside a DDR2-style memory command interface and follows the device's power state from what it sees on the pins. On every rising clock edge it samples the clock-enable level and the four active-low command strobes. It also takes a count of open banks and a flag that says a read, write, mode-register or precharge operation is still running. From these inputs it works out whether the device is all-banks-idle, banks-active, in precharge power down, in active power down, or in self refresh.

Each decision uses three things: the clock-enable level on the previous edge, the level on the current edge, and the state held just before the current edge. The tracker also checks the rules around these transitions. Only a no-operation or deselect command may be issued when power down is entered or left. Clock enable must keep a new level for a minimum number of edges. Self-refresh exit has a command-free window and a longer window in which reads are not allowed. Any entry made while an operation is in progress is also checked.

The block produces the current state, one-cycle pulses for entry and exit events, and sticky error flags that a bus monitor or a simulation scoreboard can read.

Top module: `cke_power_tracker`

## Requirements
- R1: Reset is synchronous and active low. It sets the state to all-banks-idle (encoding 0) and drives every event and error output low. After reset, the first active edge only records the clock-enable level. It makes no transition and raises no error.
- R2: When clock enable is high on both the previous and the current edge, the state becomes banks-active (encoding 1) if the open-bank count is nonzero. Otherwise it becomes all-banks-idle (encoding 0).
- R3: Commands are decoded from {cs_n, ras_n, cas_n, we_n}. Deselect is cs_n high. No-operation is 0111. When clock enable falls with deselect or no-operation from idle or active, the state becomes active power down (encoding 3) if any bank is open, or precharge power down (encoding 2) if none is open. The power-down entry pulse is raised.
- R4: The refresh command is 0001. Refresh registered on a falling clock-enable edge, from idle with zero open banks, enters self refresh (encoding 4) and pulses the self-refresh entry event. Refresh from any other condition raises the transition error, enters the power-down state chosen by the bank count and pulses power-down entry.
- R5: While clock enable stays low, the power-down or self-refresh state is held, whatever the command pins show. No error is raised.
- R6: A rising clock enable leaves power down or self refresh with these targets: active power down goes to banks-active, precharge power down goes to idle, self refresh goes to idle. The matching exit pulse is raised. Any command other than no-operation or deselect on that edge raises the transition error.
- R7: A clock-enable change registered fewer than 3 edges after the previous change (the changing edge counts as the first) raises the clock-enable width error.
- R8: After a self-refresh exit edge, number the following edges k = 1, 2, and so on. Any command other than no-operation or deselect with k below SR_CMD_DLY (default 10) raises the exit-window error. At k = SR_CMD_DLY other commands are accepted.
- R9: The read command is 0101. A read with k below SR_READ_DLY (default 200) after a self-refresh exit raises the exit-window error. A read at k = SR_READ_DLY does not.
- R10: A power-down or self-refresh entry made while op_busy is high raises the busy-entry error.
- R11: Any combination not covered above raises the transition error. This includes clock enable low on two edges while idle or active, and a falling edge with a command other than no-operation, deselect or refresh.
- R12: Outputs are registered and show the result of an edge in the cycle after it. Event pulses last one cycle. Error flags stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Registered clock-enable level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| open_banks | input | BANK_CNT_W | Number of banks currently open |
| op_busy | input | 1 | Read, write, mode-register or precharge in progress |
| pwr_state | output | 3 | Current power state (0 idle, 1 active, 2 precharge PD, 3 active PD, 4 self refresh) |
| ev_pd_entry | output | 1 | Power-down entry pulse |
| ev_pd_exit | output | 1 | Power-down exit pulse |
| ev_sr_entry | output | 1 | Self-refresh entry pulse |
| ev_sr_exit | output | 1 | Self-refresh exit pulse |
| err_transition | output | 1 | Sticky illegal transition or command |
| err_cke_width | output | 1 | Sticky clock-enable minimum width error |
| err_busy_entry | output | 1 | Sticky entry-while-busy error |
| err_sr_window | output | 1 | Sticky self-refresh exit-window error |

## Verification
The falling edge is driven with a zero and a nonzero bank count and with no-operation, deselect, refresh and an ordinary command. This separates the two power-down targets, self refresh, and the illegal entries. Low-hold periods carry refresh, read and activate patterns to show that the command pins are ignored. Rising edges carry both legal and illegal commands. The exit windows are probed one edge before and exactly at each limit: an activate at k=9 and k=10, and a read at k=199 and k=200. Clock-enable pulses of two edges and of three or more edges separate the width error from legal toggling.

// File: rtl/cke_trk_pkg.sv
// Shared types for the clock-enable power state tracker.
// Assumes: state encodings are visible at the top ports and must stay fixed.
package cke_trk_pkg;

    typedef enum logic [2:0] {
        PS_IDLE     = 3'd0,
        PS_ACTIVE   = 3'd1,
        PS_PRE_PD   = 3'd2,
        PS_ACT_PD   = 3'd3,
        PS_SELF_REF = 3'd4
    } pwr_state_e;

    typedef enum logic [2:0] {
        CMD_DESEL   = 3'd0,
        CMD_NOP     = 3'd1,
        CMD_REFRESH = 3'd2,
        CMD_READ    = 3'd3,
        CMD_OTHER   = 3'd4
    } cmd_e;

    typedef struct packed {
        logic pd_entry;
        logic pd_exit;
        logic sr_entry;
        logic sr_exit;
    } pwr_events_t;

endpackage

// File: rtl/cke_cmd_decode.sv
// Classifies the active-low command strobes into the few command classes
// the tracker cares about. Purely combinational.
// Assumes: strobes are already registered by the interface.
module cke_cmd_decode
    import cke_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd,
    output logic quiet_cmd
);

    // Map the strobe pattern onto a command class.
    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b001:  cmd = CMD_REFRESH;
                3'b101:  cmd = CMD_READ;
                default: cmd = CMD_OTHER;
            endcase
        end
    end

    // Deselect and no-operation are the only commands legal around transitions.
    always_comb quiet_cmd = (cmd == CMD_DESEL) || (cmd == CMD_NOP);

endmodule

// File: rtl/cke_width_monitor.sv
// Counts edges since the last clock-enable change and flags a change that
// arrives before MIN_EDGES edges at the previous level.
// Assumes: hist_vld is low only on the first edge after reset.
module cke_width_monitor #(
    parameter int unsigned MIN_EDGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hist_vld,
    input  logic cke,
    input  logic cke_prev,
    output logic width_viol
);

    localparam int unsigned RUN_W = $clog2(MIN_EDGES + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_EDGES);

    logic [RUN_W-1:0] run_q;
    logic             level_change;

    // A change is a difference between this edge and the previous edge.
    always_comb level_change = hist_vld && (cke != cke_prev);

    // Saturating count of edges spent at the current level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= RUN_MAX;
        end else if (!hist_vld) begin
            run_q <= RUN_MAX;
        end else if (level_change) begin
            run_q <= RUN_W'(1);
        end else if (run_q < RUN_MAX) begin
            run_q <= run_q + RUN_W'(1);
        end
    end

    // Flag a change that comes before the old level was held long enough.
    always_comb width_viol = level_change && (run_q < RUN_MAX);

    AST_RUN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q != '0) && (run_q <= RUN_MAX)); // R7

endmodule

// File: rtl/cke_sr_exit_window.sv
// Times the edges after a self-refresh exit and flags commands that come
// too early: any non-quiet command before CMD_DLY, any read before READ_DLY.
// Assumes: CMD_DLY <= READ_DLY and READ_DLY >= 2.
module cke_sr_exit_window
    import cke_trk_pkg::*;
#(
    parameter int unsigned CMD_DLY  = 10,
    parameter int unsigned READ_DLY = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_exit_now,
    input  cmd_e cmd,
    input  logic quiet_cmd,
    output logic window_viol
);

    localparam int unsigned CNT_W = $clog2(READ_DLY + 1);
    localparam logic [CNT_W-1:0] CMD_LIM  = CNT_W'(CMD_DLY);
    localparam logic [CNT_W-1:0] READ_LIM = CNT_W'(READ_DLY);

    logic             active_q;
    logic [CNT_W-1:0] edge_k_q;

    // Edge index k since the exit edge; the window closes after edge READ_DLY-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            edge_k_q <= '0;
        end else if (sr_exit_now) begin
            active_q <= 1'b1;
            edge_k_q <= CNT_W'(1);
        end else if (active_q) begin
            if (edge_k_q >= READ_LIM - CNT_W'(1)) begin
                active_q <= 1'b0;
            end
            edge_k_q <= edge_k_q + CNT_W'(1);
        end
    end

    // Judge the command on this edge against both windows.
    always_comb begin
        window_viol = 1'b0;
        if (active_q) begin
            if (!quiet_cmd && (edge_k_q < CMD_LIM)) window_viol = 1'b1;
            if ((cmd == CMD_READ) && (edge_k_q < READ_LIM)) window_viol = 1'b1;
        end
    end

    AST_WINDOW_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> ((edge_k_q != '0) && (edge_k_q < READ_LIM))); // R9

    AST_WINDOW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        sr_exit_now |=> active_q); // R8

endmodule

// File: rtl/cke_power_fsm.sv
// Power state machine. Each edge is decided by the previous and current
// clock-enable levels and the state held before the edge. Emits one-cycle
// event pulses and raw (non-sticky) violation strobes for this edge.
// Assumes: hist_vld is low only on the first edge after reset.
module cke_power_fsm
    import cke_trk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hist_vld,
    input  logic        cke,
    input  logic        cke_prev,
    input  cmd_e        cmd,
    input  logic        quiet_cmd,
    input  logic        bank_open,
    input  logic        op_busy,
    output pwr_state_e  state_q,
    output pwr_events_t events_q,
    output logic        trans_viol,
    output logic        busy_viol,
    output logic        sr_exit_now
);

    pwr_state_e  state_d;
    pwr_events_t events_d;
    pwr_state_e  pd_target;
    logic        awake;
    logic        asleep;

    // Classify the pre-edge state and the power-down target for an entry.
    always_comb begin
        awake     = (state_q == PS_IDLE) || (state_q == PS_ACTIVE);
        asleep    = (state_q == PS_PRE_PD) || (state_q == PS_ACT_PD) ||
                    (state_q == PS_SELF_REF);
        pd_target = bank_open ? PS_ACT_PD : PS_PRE_PD;
    end

    // Transition table over {previous CKE, current CKE} and the current state.
    always_comb begin
        state_d     = state_q;
        events_d    = '0;
        trans_viol  = 1'b0;
        busy_viol   = 1'b0;
        sr_exit_now = 1'b0;
        if (hist_vld) begin
            unique case ({cke_prev, cke})
                2'b11: begin
                    if (awake) begin
                        state_d = bank_open ? PS_ACTIVE : PS_IDLE;
                    end else begin
                        trans_viol = 1'b1;
                    end
                end
                2'b10: begin
                    if (awake) begin
                        busy_viol = op_busy;
                        if ((cmd == CMD_REFRESH) && (state_q == PS_IDLE) && !bank_open) begin
                            state_d           = PS_SELF_REF;
                            events_d.sr_entry = 1'b1;
                        end else begin
                            state_d           = pd_target;
                            events_d.pd_entry = 1'b1;
                            trans_viol        = !quiet_cmd;
                        end
                    end else begin
                        trans_viol = 1'b1;
                    end
                end
                2'b00: begin
                    if (!asleep) begin
                        trans_viol = 1'b1;
                    end
                end
                default: begin
                    unique case (state_q)
                        PS_PRE_PD: begin
                            state_d          = PS_IDLE;
                            events_d.pd_exit = 1'b1;
                            trans_viol       = !quiet_cmd;
                        end
                        PS_ACT_PD: begin
                            state_d          = PS_ACTIVE;
                            events_d.pd_exit = 1'b1;
                            trans_viol       = !quiet_cmd;
                        end
                        PS_SELF_REF: begin
                            state_d          = PS_IDLE;
                            events_d.sr_exit = 1'b1;
                            sr_exit_now      = 1'b1;
                            trans_viol       = !quiet_cmd;
                        end
                        default: trans_viol = 1'b1;
                    endcase
                end
            endcase
        end
    end

    // Register the state and the event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PS_IDLE;
            events_q <= '0;
        end else begin
            state_q  <= state_d;
            events_q <= events_d;
        end
    end

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(events_q)); // R12

    AST_LOW_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_vld && !cke_prev && !cke && asleep) |=> $stable(state_q)); // R5

    AST_SR_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        events_q.sr_entry |-> ($past(state_q) == PS_IDLE)); // R4

    AST_EXIT_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (events_q.pd_exit || events_q.sr_exit) |-> ($past(cke) && !$past(cke_prev))); // R6

    AST_ENTRY_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (events_q.pd_entry || events_q.sr_entry) |-> (!$past(cke) && $past(cke_prev))); // R3

endmodule

// File: rtl/cke_power_tracker.sv
// Top of the clock-enable power state tracker. Holds the clock-enable
// history, ties the decoder, state machine and timing monitors together and
// keeps the sticky error flags.
// Assumes: all inputs are synchronous to clk; open_banks never exceeds BANKS.
module cke_power_tracker
    import cke_trk_pkg::*;
#(
    parameter int unsigned BANKS       = 8,
    parameter int unsigned BANK_CNT_W  = $clog2(BANKS + 1),
    parameter int unsigned CKE_MIN     = 3,
    parameter int unsigned SR_CMD_DLY  = 10,
    parameter int unsigned SR_READ_DLY = 200
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cke,
    input  logic                  cs_n,
    input  logic                  ras_n,
    input  logic                  cas_n,
    input  logic                  we_n,
    input  logic [BANK_CNT_W-1:0] open_banks,
    input  logic                  op_busy,
    output logic [2:0]            pwr_state,
    output logic                  ev_pd_entry,
    output logic                  ev_pd_exit,
    output logic                  ev_sr_entry,
    output logic                  ev_sr_exit,
    output logic                  err_transition,
    output logic                  err_cke_width,
    output logic                  err_busy_entry,
    output logic                  err_sr_window
);

    logic        hist_vld_q;
    logic        cke_prev_q;
    cmd_e        cmd;
    logic        quiet_cmd;
    logic        bank_open;
    pwr_state_e  state_q;
    pwr_events_t events_q;
    logic        trans_viol;
    logic        busy_viol;
    logic        sr_exit_now;
    logic        width_viol;
    logic        window_viol;

    // Any nonzero bank count means at least one row is open.
    always_comb bank_open = (open_banks != '0);

    // Clock-enable history: the first edge after reset only fills it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_vld_q <= 1'b0;
            cke_prev_q <= 1'b0;
        end else begin
            hist_vld_q <= 1'b1;
            cke_prev_q <= cke;
        end
    end

    cke_cmd_decode u_decode (
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .cmd       (cmd),
        .quiet_cmd (quiet_cmd)
    );

    cke_power_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hist_vld    (hist_vld_q),
        .cke         (cke),
        .cke_prev    (cke_prev_q),
        .cmd         (cmd),
        .quiet_cmd   (quiet_cmd),
        .bank_open   (bank_open),
        .op_busy     (op_busy),
        .state_q     (state_q),
        .events_q    (events_q),
        .trans_viol  (trans_viol),
        .busy_viol   (busy_viol),
        .sr_exit_now (sr_exit_now)
    );

    cke_width_monitor #(
        .MIN_EDGES (CKE_MIN)
    ) u_width (
        .clk        (clk),
        .rst_n      (rst_n),
        .hist_vld   (hist_vld_q),
        .cke        (cke),
        .cke_prev   (cke_prev_q),
        .width_viol (width_viol)
    );

    cke_sr_exit_window #(
        .CMD_DLY  (SR_CMD_DLY),
        .READ_DLY (SR_READ_DLY)
    ) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .sr_exit_now (sr_exit_now),
        .cmd         (cmd),
        .quiet_cmd   (quiet_cmd),
        .window_viol (window_viol)
    );

    // Sticky error flags, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_transition <= 1'b0;
            err_cke_width  <= 1'b0;
            err_busy_entry <= 1'b0;
            err_sr_window  <= 1'b0;
        end else begin
            err_transition <= err_transition | trans_viol;
            err_cke_width  <= err_cke_width  | width_viol;
            err_busy_entry <= err_busy_entry | busy_viol;
            err_sr_window  <= err_sr_window  | window_viol;
        end
    end

    // Drive the state and event ports from the state machine.
    always_comb begin
        pwr_state   = state_q;
        ev_pd_entry = events_q.pd_entry;
        ev_pd_exit  = events_q.pd_exit;
        ev_sr_entry = events_q.sr_entry;
        ev_sr_exit  = events_q.sr_exit;
    end

    AST_ERRORS_STICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_transition) |-> err_transition) and
        ($past(err_cke_width)  |-> err_cke_width)  and
        ($past(err_busy_entry) |-> err_busy_entry) and
        ($past(err_sr_window)  |-> err_sr_window)); // R12

    AST_BUSY_ONLY_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_busy_entry ##1 err_busy_entry) |-> ($past(ev_pd_entry || ev_sr_entry, 1) || ev_pd_entry || ev_sr_entry)); // R10

endmodule

// File: tb/cke_power_tracker_bench.sv
`timescale 1ns/1ps
module cke_power_tracker_bench;

    localparam real CLK_HALF = 2.5;
    localparam int  BW = 4;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_DES = 4'b1111;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_ACT = 4'b0011;

    localparam logic [2:0] S_IDLE = 3'd0;
    localparam logic [2:0] S_ACT  = 3'd1;
    localparam logic [2:0] S_PPD  = 3'd2;
    localparam logic [2:0] S_APD  = 3'd3;
    localparam logic [2:0] S_SR   = 3'd4;

    // event vector {pd_entry, pd_exit, sr_entry, sr_exit}
    localparam logic [3:0] E_NONE = 4'b0000;
    localparam logic [3:0] E_PDI  = 4'b1000;
    localparam logic [3:0] E_PDO  = 4'b0100;
    localparam logic [3:0] E_SRI  = 4'b0010;
    localparam logic [3:0] E_SRO  = 4'b0001;

    // error vector {transition, cke_width, busy_entry, sr_window}
    localparam int ER_TR = 3;
    localparam int ER_CW = 2;
    localparam int ER_BZ = 1;
    localparam int ER_SW = 0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke = 1'b1;
    logic [3:0]    cmd_pins = 4'b0111;
    logic [BW-1:0] banks = '0;
    logic          busy = 1'b0;
    logic [2:0]    pwr_state;
    logic          ev_pd_entry, ev_pd_exit, ev_sr_entry, ev_sr_exit;
    logic          err_transition, err_cke_width, err_busy_entry, err_sr_window;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [3:0] exp_err = '0;

    typedef struct {
        int         due;
        logic [2:0] st;
        logic [3:0] ev;
        logic [3:0] er;
        string      tag;
    } exp_t;
    exp_t sb[$];

    cke_power_tracker u_cke_power_tracker (
        .clk            (clk),
        .rst_n          (rst_n),
        .cke            (cke),
        .cs_n           (cmd_pins[3]),
        .ras_n          (cmd_pins[2]),
        .cas_n          (cmd_pins[1]),
        .we_n           (cmd_pins[0]),
        .open_banks     (banks),
        .op_busy        (busy),
        .pwr_state      (pwr_state),
        .ev_pd_entry    (ev_pd_entry),
        .ev_pd_exit     (ev_pd_exit),
        .ev_sr_entry    (ev_sr_entry),
        .ev_sr_exit     (ev_sr_exit),
        .err_transition (err_transition),
        .err_cke_width  (err_cke_width),
        .err_busy_entry (err_busy_entry),
        .err_sr_window  (err_sr_window)
    );

    always #(CLK_HALF) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop items due this cycle and compare away from the edge.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t it;
            logic [3:0] ev_a;
            logic [3:0] er_a;
            it = sb.pop_front();
            ev_a = {ev_pd_entry, ev_pd_exit, ev_sr_entry, ev_sr_exit};
            er_a = {err_transition, err_cke_width, err_busy_entry, err_sr_window};
            total++;
            if (pwr_state !== it.st || ev_a !== it.ev || er_a !== it.er) begin
                bad++;
                $display("FAIL %s cyc=%0d: state=%0d ev=%b err=%b expected state=%0d ev=%b err=%b",
                         it.tag, cyc, pwr_state, ev_a, er_a, it.st, it.ev, it.er);
            end
        end
    end

    // Driver: apply one edge's inputs and queue the expected result.
    task automatic step(input logic c, input logic [3:0] cp, input logic [BW-1:0] nb,
                        input logic bz, input logic [2:0] st, input logic [3:0] ev,
                        input string tag);
        exp_t it;
        cke = c; cmd_pins = cp; banks = nb; busy = bz;
        it.due = cyc + 1; it.st = st; it.ev = ev; it.er = exp_err; it.tag = tag;
        sb.push_back(it);
        @(posedge clk);
        #1;
    endtask

    // Reset with a given CKE level, then check the reset state (R1).
    task automatic do_reset(input logic c);
        rst_n = 1'b0; cke = c; cmd_pins = C_NOP; banks = '0; busy = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        exp_err = '0;
        total++;
        if (pwr_state !== S_IDLE ||
            {ev_pd_entry, ev_pd_exit, ev_sr_entry, ev_sr_exit} !== 4'b0 ||
            {err_transition, err_cke_width, err_busy_entry, err_sr_window} !== 4'b0) begin
            bad++;
            $display("FAIL R1 reset: state=%0d ev=%b err=%b expected state=0 ev=0000 err=0000",
                     pwr_state, {ev_pd_entry, ev_pd_exit, ev_sr_entry, ev_sr_exit},
                     {err_transition, err_cke_width, err_busy_entry, err_sr_window});
        end
    endtask

    task automatic high_idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1, C_NOP, '0, 1'b0, S_IDLE, E_NONE, "R2 idle high");
    endtask

    // Legal self-refresh entry and exit from a fresh reset (R4, R5, R6).
    task automatic sr_prefix();
        high_idle(3);
        step(1'b0, C_REF, '0, 1'b0, S_SR, E_SRI, "R4 sr entry");
        step(1'b0, C_ACT, 4'd2, 1'b0, S_SR, E_NONE, "R5 sr hold");
        step(1'b0, C_RD,  '0, 1'b0, S_SR, E_NONE, "R5 sr hold");
        step(1'b0, C_NOP, '0, 1'b0, S_SR, E_NONE, "R5 sr hold");
        step(1'b1, C_NOP, '0, 1'b0, S_IDLE, E_SRO, "R6 sr exit");
    endtask

    initial begin
        do_reset(1'b1);
        // R1 first edge only records history; R2 bank-count tracking
        step(1'b1, C_NOP, '0,   1'b0, S_IDLE, E_NONE, "R1 history edge");
        step(1'b1, C_NOP, 4'd2, 1'b0, S_ACT,  E_NONE, "R2 banks open");
        step(1'b1, C_NOP, '0,   1'b0, S_IDLE, E_NONE, "R2 banks closed");
        // R3 precharge power down, R5 commands ignored while low
        step(1'b0, C_NOP, '0,   1'b0, S_PPD,  E_PDI,  "R3 precharge pd");
        step(1'b0, C_ACT, '0,   1'b0, S_PPD,  E_NONE, "R5 hold");
        step(1'b0, C_REF, 4'd3, 1'b0, S_PPD,  E_NONE, "R5 hold");
        step(1'b0, C_RD,  '0,   1'b0, S_PPD,  E_NONE, "R5 hold");
        step(1'b1, C_DES, '0,   1'b0, S_IDLE, E_PDO,  "R6 pd exit to idle");
        step(1'b1, C_NOP, 4'd3, 1'b0, S_ACT,  E_NONE, "R2 active");
        step(1'b1, C_NOP, 4'd3, 1'b0, S_ACT,  E_NONE, "R2 active");
        // R3 active power down, exit to active
        step(1'b0, C_DES, 4'd3, 1'b0, S_APD,  E_PDI,  "R3 active pd");
        step(1'b0, C_NOP, 4'd3, 1'b0, S_APD,  E_NONE, "R5 hold");
        step(1'b0, C_NOP, 4'd3, 1'b0, S_APD,  E_NONE, "R5 hold");
        step(1'b1, C_NOP, '0,   1'b0, S_ACT,  E_PDO,  "R6 pd exit to active");
        step(1'b1, C_NOP, '0,   1'b0, S_IDLE, E_NONE, "R2 idle");
        step(1'b1, C_NOP, 4'd1, 1'b0, S_ACT,  E_NONE, "R2 active");
        // R4 refresh while a bank is open: illegal, power down instead
        exp_err[ER_TR] = 1'b1;
        step(1'b0, C_REF, 4'd1, 1'b0, S_APD,  E_PDI,  "R4 refresh not idle");
        step(1'b0, C_NOP, 4'd1, 1'b0, S_APD,  E_NONE, "R12 sticky");
        step(1'b0, C_NOP, 4'd1, 1'b0, S_APD,  E_NONE, "R12 sticky");
        step(1'b1, C_NOP, 4'd1, 1'b0, S_ACT,  E_PDO,  "R12 sticky");

        // R8 non-quiet command at k=9 is an error
        do_reset(1'b1);
        sr_prefix();
        for (int k = 1; k <= 8; k++) step(1'b1, C_NOP, '0, 1'b0, S_IDLE, E_NONE, "R8 window nop");
        exp_err[ER_SW] = 1'b1;
        step(1'b1, C_ACT, '0, 1'b0, S_IDLE, E_NONE, "R8 command at k=9");

        // R8 k=10 accepted; R9 read at k=199 is an error
        do_reset(1'b1);
        sr_prefix();
        for (int k = 1; k <= 9; k++) step(1'b1, C_DES, '0, 1'b0, S_IDLE, E_NONE, "R8 window des");
        step(1'b1, C_ACT, '0, 1'b0, S_IDLE, E_NONE, "R8 command at k=10");
        for (int k = 11; k <= 198; k++) step(1'b1, C_NOP, '0, 1'b0, S_IDLE, E_NONE, "R9 window nop");
        exp_err[ER_SW] = 1'b1;
        step(1'b1, C_RD, '0, 1'b0, S_IDLE, E_NONE, "R9 read at k=199");

        // R9 read at k=200 accepted
        do_reset(1'b1);
        sr_prefix();
        for (int k = 1; k <= 199; k++) step(1'b1, C_NOP, '0, 1'b0, S_IDLE, E_NONE, "R9 window nop");
        step(1'b1, C_RD, '0, 1'b0, S_IDLE, E_NONE, "R9 read at k=200");
        step(1'b1, C_RD, '0, 1'b0, S_IDLE, E_NONE, "R9 read at k=201");

        // R10 entry while busy
        do_reset(1'b1);
        high_idle(3);
        exp_err[ER_BZ] = 1'b1;
        step(1'b0, C_NOP, '0, 1'b1, S_PPD, E_PDI, "R10 busy entry");
        step(1'b0, C_NOP, '0, 1'b0, S_PPD, E_NONE, "R10 hold");
        step(1'b0, C_NOP, '0, 1'b0, S_PPD, E_NONE, "R10 hold");
        step(1'b1, C_NOP, '0, 1'b0, S_IDLE, E_PDO, "R10 exit");

        // R7 low pulse of only two edges
        do_reset(1'b1);
        high_idle(3);
        step(1'b0, C_NOP, '0, 1'b0, S_PPD, E_PDI, "R7 entry");
        step(1'b0, C_NOP, '0, 1'b0, S_PPD, E_NONE, "R7 hold");
        exp_err[ER_CW] = 1'b1;
        step(1'b1, C_NOP, '0, 1'b0, S_IDLE, E_PDO, "R7 short low pulse");

        // R6 illegal command on exit
        do_reset(1'b1);
        high_idle(3);
        step(1'b0, C_NOP, '0, 1'b0, S_PPD, E_PDI, "R6 entry");
        step(1'b0, C_NOP, '0, 1'b0, S_PPD, E_NONE, "R6 hold");
        step(1'b0, C_NOP, '0, 1'b0, S_PPD, E_NONE, "R6 hold");
        exp_err[ER_TR] = 1'b1;
        step(1'b1, C_ACT, '0, 1'b0, S_IDLE, E_PDO, "R6 command on exit");

        // R11 falling edge with an ordinary command
        do_reset(1'b1);
        high_idle(3);
        exp_err[ER_TR] = 1'b1;
        step(1'b0, C_ACT, '0, 1'b0, S_PPD, E_PDI, "R11 command on entry");

        // R11 CKE low on two edges while idle
        do_reset(1'b0);
        step(1'b0, C_NOP, '0, 1'b0, S_IDLE, E_NONE, "R1 history low");
        exp_err[ER_TR] = 1'b1;
        step(1'b0, C_NOP, '0, 1'b0, S_IDLE, E_NONE, "R11 low while idle");

        @(negedge clk);
        @(negedge clk);
        if (sb.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R12 queue: left=%0d expected=0", sb.size());
        end
        do_reset(1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #(CLK_HALF * 2.0 * 150000.0);
        total++;
        bad++;
        $display("FAIL watchdog: cyc=%0d expected completion", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule